// File: doc/BRIEF.md
# I2C SCL Clock Phase Generator

This block produces the SCL waveform for an I2C bus master from a fast system clock. A power-of-two prescaler divides the system clock into ticks. Two phase lengths, one for the high part of SCL and one for the low part, are counted in those ticks. All three values come from one 32-bit timing word. Each phase length is stored as its length minus one, so a stored zero still gives a phase of one tick. One full SCL period therefore lasts `2^exp * ((high+1) + (low+1))` system clock cycles.

While the block runs, it pulls SCL low during the low phase and releases it during the high phase. The high phase counts only while the sensed SCL line reads high, so a target that holds SCL low stretches the clock. Each time the block pulls SCL low it gives a one-cycle fall strobe, and each time it releases SCL it gives a one-cycle rise strobe. A byte engine uses these strobes to launch and sample data. When the enable is low, SCL is released and every counter is held at zero.

Top module: `scl_clock_gen`

## Requirements
- R1: During and right after a synchronous reset, `scl_drive_low`, `rise_stb` and `fall_stb` are all 0.
- R2: While `run_en` is 0, from the next cycle on, SCL is released and no strobe fires. After `run_en` rises again, the timing starts from zero, with the same delays as a fresh start.
- R3: From the cycle `run_en` is first seen high, the high phase comes first. `fall_stb` fires `2^exp*(high+1)+1` cycles later, counting the first sampling cycle as 1. Between a `rise_stb` and the next `fall_stb` there are `2^exp*(high+1)` cycles when there is no stretching.
- R4: From a `fall_stb` to the next `rise_stb` there are `2^exp*(low+1)` cycles.
- R5: The prescale factor is `2^exp` for every `exp` from 0 to 15, including the largest value, 32768.
- R6: The timing word holds the high count in bits [19:16], the low count in bits [15:12] and the exponent in bits [3:0]. All other bits have no effect on the timing.
- R7: A stored phase count of 0 gives a phase of exactly one prescaled tick.
- R8: While the block is in its high phase and `scl_sense` reads 0, the phase count is frozen. The high phase grows by exactly the number of stretched cycles.
- R9: Each strobe is exactly one cycle wide, and the two strobes never fire in the same cycle. `fall_stb` fires in the first cycle that `scl_drive_low` is 1. `rise_stb` fires in the first cycle that it is 0 again.
- R10: Starting from idle gives no `rise_stb`, because SCL is already released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run the clock generator; 0 releases SCL and clears the counters |
| timing_word | input | 32 | Exponent [3:0], low count [15:12], high count [19:16] |
| scl_sense | input | 1 | Sampled level of the real SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| rise_stb | output | 1 | One-cycle pulse in the first released cycle after a low phase |
| fall_stb | output | 1 | One-cycle pulse in the first pulled-low cycle |

## Verification
The bench measures the gaps between strobes for several exponent and count pairs. It checks these cases:
- **Stored zero.** A design that takes the stored count as the real length gets a zero-length phase wrong.
- **Off-by-one prescaler.** A design whose prescaler is one count off drifts by one cycle per tick.
- **Exponent of 15.** A design that truncates the prescaler width fails only at this largest exponent.
- **Stray bits in the timing word.** Noise bits are set around the fields, so a design that reads the wrong field positions shows a changed period.
- **Stretch.** SCL is held low for a known count, so a design that counts through the stretch gives a high phase that is too short.
- **Mid-phase disable.** A design that keeps stale counter values gives an early first edge after re-enable.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    parameter int CFG_W   = 32;
    parameter int EXP_W   = 4;
    parameter int PH_W    = 4;
    parameter int HI_LSB  = 16;
    parameter int LO_LSB  = 12;
    parameter int EXP_LSB = 0;

    localparam int PRE_W = (1 << EXP_W) - 1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [PH_W-1:0]  high_m1;
        logic [PH_W-1:0]  low_m1;
        logic [EXP_W-1:0] exp;
    } timing_t;

    function automatic timing_t unpack_timing(input logic [CFG_W-1:0] w);
        timing_t t;
        t.high_m1 = w[HI_LSB  +: PH_W];
        t.low_m1  = w[LO_LSB  +: PH_W];
        t.exp     = w[EXP_LSB +: EXP_W];
        return t;
    endfunction

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    input  logic [EXP_W-1:0] exp,
    output logic             tick
);
    localparam int CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = {CNT_W{1'b1}} >> (CNT_W - int'(exp));
        tick  = advance && !clear && (cnt_q == limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            tick,
    input  logic [PH_W-1:0] limit,
    output logic            done
);
    logic [PH_W-1:0] cnt_q;

    assign done = tick && !clear && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= done ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
    import scl_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [CFG_W-1:0] timing_word,
    input  logic             scl_sense,
    output logic             scl_drive_low,
    output logic             rise_stb,
    output logic             fall_stb
);
    timing_t         tcfg;
    phase_e          state_q, state_d;
    logic            clear, advance, tick, phase_done;
    logic [PH_W-1:0] limit;
    logic            rise_q, fall_q;

    assign tcfg = unpack_timing(timing_word);

    always_comb begin
        clear   = !run_en || (state_q == PH_IDLE);
        advance = (state_q == PH_LOW) || ((state_q == PH_HIGH) && scl_sense);
        limit   = (state_q == PH_LOW) ? tcfg.low_m1 : tcfg.high_m1;
    end

    scl_prescaler #(.EXP_W(EXP_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .advance (advance),
        .exp     (tcfg.exp),
        .tick    (tick)
    );

    scl_phase_counter #(.PH_W(PH_W)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .tick  (tick),
        .limit (limit),
        .done  (phase_done)
    );

    always_comb begin
        state_d = state_q;
        if (!run_en) begin
            state_d = PH_IDLE;
        end else begin
            case (state_q)
                PH_IDLE: state_d = PH_HIGH;
                PH_HIGH: if (phase_done) state_d = PH_LOW;
                PH_LOW:  if (phase_done) state_d = PH_HIGH;
                default: state_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fall_q  <= (state_q == PH_HIGH) && (state_d == PH_LOW);
            rise_q  <= (state_q == PH_LOW) && (state_d == PH_HIGH);
        end
    end

    assign scl_drive_low = (state_q == PH_LOW);
    assign rise_stb      = rise_q;
    assign fall_stb      = fall_q;

    // R9: strobes are single-cycle and mutually exclusive
    a_r9_rise_one_wide: assert property (@(posedge clk) disable iff (rst)
        rise_stb |=> !rise_stb);
    a_r9_fall_one_wide: assert property (@(posedge clk) disable iff (rst)
        fall_stb |=> !fall_stb);
    a_r9_never_both: assert property (@(posedge clk) disable iff (rst)
        !(rise_stb && fall_stb));
    a_r9_fall_with_drive: assert property (@(posedge clk) disable iff (rst)
        fall_stb |-> scl_drive_low);
    a_r9_rise_released: assert property (@(posedge clk) disable iff (rst)
        rise_stb |-> !scl_drive_low);
    // R2: disabled block releases SCL and stays quiet
    a_r2_released_when_off: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!scl_drive_low && !rise_stb && !fall_stb));
    // R8: a stretched high phase cannot end
    a_r8_hold_while_stretched: assert property (@(posedge clk) disable iff (rst)
        (run_en && state_q == PH_HIGH && !scl_sense) |=> !fall_stb);
endmodule

// File: tb/test_scl_clock_gen.sv
module test_scl_clock_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        run_en;
    logic [31:0] timing_word;
    logic        stretch_hold;
    logic        scl_sense;
    logic        scl_drive_low, rise_stb, fall_stb;

    int checks = 0;
    int errors = 0;
    int strobe_bad = 0;
    bit done = 1'b0;
    bit prev_rise = 1'b0, prev_fall = 1'b0;

    always #2 clk = ~clk;

    assign scl_sense = !scl_drive_low && !stretch_hold;

    scl_clock_gen i_scl_clock_gen (
        .clk           (clk),
        .rst           (rst),
        .run_en        (run_en),
        .timing_word   (timing_word),
        .scl_sense     (scl_sense),
        .scl_drive_low (scl_drive_low),
        .rise_stb      (rise_stb),
        .fall_stb      (fall_stb)
    );

    // R9 monitor: strobe width, exclusivity, alignment with drive
    always @(negedge clk) begin
        if (!rst) begin
            if (rise_stb && fall_stb) strobe_bad++;
            if (rise_stb && prev_rise) strobe_bad++;
            if (fall_stb && prev_fall) strobe_bad++;
            if (fall_stb && !scl_drive_low) strobe_bad++;
            if (rise_stb && scl_drive_low) strobe_bad++;
        end
        prev_rise = rise_stb;
        prev_fall = fall_stb;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic logic [31:0] word(input int e, input int h, input int l);
        return (32'(h) << 16) | (32'(l) << 12) | 32'(e);
    endfunction

    // counts negedges until the chosen strobe is seen (1 = rise, 0 = fall)
    task automatic wait_stb(input bit want_rise, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(want_rise ? rise_stb : fall_stb) && n < 70000);
    endtask

    task automatic t_reset;
        rst = 1'b1; run_en = 1'b0; stretch_hold = 1'b0; timing_word = '0;
        repeat (3) @(negedge clk);
        chk(!scl_drive_low && !rise_stb && !fall_stb, "R1 reset outputs", scl_drive_low, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!scl_drive_low && !rise_stb && !fall_stb, "R1 after reset", scl_drive_low, 0);
    endtask

    task automatic t_period(input int e, input int h, input int l, input logic [31:0] junk,
                            input string req);
        int n;
        int p = 1 << e;
        int sawrise = 0;
        timing_word = word(e, h, l) | junk;
        run_en = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (rise_stb) sawrise++;
        end while (!fall_stb && n < 70000);
        chk(n == p * (h + 1) + 1, {req, " R3 enable to first fall"}, n, p * (h + 1) + 1);
        chk(sawrise == 0, "R10 no rise at start", sawrise, 0);
        wait_stb(1'b1, n);
        chk(n == p * (l + 1), {req, " R4 low phase"}, n, p * (l + 1));
        wait_stb(1'b0, n);
        chk(n == p * (h + 1), {req, " R3 high phase"}, n, p * (h + 1));
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_stretch;
        int n;
        timing_word = word(1, 2, 1);
        run_en = 1'b1;
        wait_stb(1'b1, n);
        stretch_hold = 1'b1;
        repeat (5) @(negedge clk);
        stretch_hold = 1'b0;
        wait_stb(1'b0, n);
        n += 5;
        chk(n == 2 * 3 + 5, "R8 stretched high phase", n, 11);
        run_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_disable;
        int n;
        int quiet = 0;
        timing_word = word(2, 1, 3);
        run_en = 1'b1;
        wait_stb(1'b0, n);
        repeat (3) @(negedge clk);
        run_en = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (scl_drive_low || rise_stb || fall_stb) quiet++;
        end
        chk(quiet == 0, "R2 released while disabled", quiet, 0);
        run_en = 1'b1;
        wait_stb(1'b0, n);
        chk(n == 4 * 2 + 1, "R2 restart timing", n, 9);
        run_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_max_base;
        int n;
        timing_word = word(15, 0, 0);
        run_en = 1'b1;
        wait_stb(1'b0, n);
        chk(n == 32768 + 1, "R5 R7 max exponent high", n, 32769);
        wait_stb(1'b1, n);
        chk(n == 32768, "R5 R7 max exponent low", n, 32768);
        run_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_period(0, 0, 0, 32'h0, "R7 zero counts");
        t_period(0, 3, 5, 32'h0, "R5 exp0");
        t_period(3, 2, 4, 32'h0, "R5 exp3");
        t_period(2, 15, 15, 32'h0, "R5 full counts");
        t_period(1, 4, 2, 32'hFFF0_0FF0, "R6 noise bits");
        t_stretch();
        t_disable();
        t_max_base();
        chk(strobe_bad == 0, "R9 strobe shape", strobe_bad, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule